// File: doc/BRIEF.md
# Memory Decoder Register Bank

This block is the software-facing configuration store for a set of address-range decoders. Software reaches it over a plain 32-bit register bus with separate read and write strobes. A read returns its data one cycle after the request, together with a valid pulse. The bank holds a read-only capability word, a global enable and a small array of decoder instances. The instances sit at a fixed stride of 0x20 bytes. Each holds a 64-bit base, a 64-bit size, a control word and a 64-bit list of target identifiers.

Programming an instance ends with a commit handshake. Software sets the commit bit, and the instance reports committed only after a fixed number of clock cycles, set by the parameter `COMMIT_DELAY`. When an instance is both committed and locked, its programmed values are frozen until software clears commit again. The 64-bit registers are written as two halves. Software writes the high half first, and the value takes effect only when the low half is written, so a downstream reader never sees a torn value.

Every instance publishes its decoded settings as plain output pins for a downstream address router. These are the base, the effective size, the way count, the log2 of the granularity, the target list, the target type and the committed flag. The bus has no back-pressure: a write completes in the cycle its strobe is seen, and a read always answers on the next cycle.

Top module: `mdec_regbank`

## Requirements
- R1: After reset every writable register reads 0, every instance reports not committed, `glb_enable` is 0 and `bus_rvalid` is 0.
- R2: The word at offset 0x0 is read-only. It holds `NUM_INST` in bits 3:0 and `TGT_CNT` in bits 7:4. Bit 8 equals `IL_LO` (address bits 11:8 usable for interleave), bit 9 equals `IL_HI` (address bits 14:12 usable), and all other bits are 0.
- R3: Offset 0x4 is the global control word. Only bit 1 is stored; it drives `glb_enable`, and all other bits read 0.
- R4: A read strobe in one cycle gives `bus_rvalid` high with the data in `bus_rdata` in the next cycle. Without a strobe, `bus_rvalid` is low.
- R5: Instance i places its registers at these offsets: base low/high at 0x20*i+0x10/0x14, size low/high at 0x20*i+0x18/0x1C, control at 0x20*i+0x20, and target list low/high at 0x20*i+0x24/0x28. Each reads back what was written.
- R6: A write to a high half of base or size is staged and changes neither the readback nor the outputs. The following low-half write updates the full 64-bit value at once, from the staged high word and the new low word.
- R7: The control word fields are: granularity code in bits 3:0, ways code in bits 7:4, lock at bit 8, commit at bit 9, committed at bit 10 and target type at bit 12 (1 = memory expander, 0 = accelerator). Committed is read-only, and bits 11 and 31:13 read 0.
- R8: Suppose a control write sets commit while commit is clear. Committed stays 0 for the next `COMMIT_DELAY`-1 clock edges and becomes 1 on the `COMMIT_DELAY`-th edge after the write edge.
- R9: A control write with commit 0 clears both commit and committed at its write edge.
- R10: While an instance is committed with lock set, writes to its base, size and target list are ignored, and so are writes to every control field except commit. A write that clears commit is still accepted.
- R11: Offsets 0x8 and 0xC, the unused slot at 0x20*i+0x2C, and every instance index at or above `NUM_INST` read 0, and writes to them have no effect.
- R12: The published ways count decodes codes 0..4 to 1,2,4,8,16 and codes 8..10 to 3,6,12; other codes give 0. The granularity output is 8 plus the code (log2 of 256 shifted by the code). The effective size is 0 while the instance is not committed and the programmed size once it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| glb_enable | output | 1 | Global decoder enable |
| dec_base | output | NUM_INST*64 | Per-instance base address |
| dec_size | output | NUM_INST*64 | Per-instance size, 0 unless committed |
| dec_targets | output | NUM_INST*64 | Per-instance target list, one byte per way |
| dec_ways | output | NUM_INST*5 | Per-instance decoded way count |
| dec_gran_log2 | output | NUM_INST*5 | Per-instance log2 of interleave granularity |
| dec_expander | output | NUM_INST | Target type, 1 = memory expander |
| dec_committed | output | NUM_INST | Per-instance committed flag |

## Verification
A wrong commit counter would show at `dec_committed` as a rise one or more edges away from the expected edge, so the bench samples that pin on each side of the edge. A stale staging register or a broken lock would show at the next low-half write or readback as a base that mixes old and new words, or that changes while frozen. Address-decode faults appear on the very next read as nonzero data from a hole, or as a value that aliases into the wrong instance.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  typedef enum logic [2:0] {
    SUB_BLO, SUB_BHI, SUB_SLO, SUB_SHI, SUB_CTRL, SUB_TLO, SUB_THI, SUB_NONE
  } sub_e;

  localparam int CTL_LOCK   = 8;
  localparam int CTL_COMMIT = 9;
  localparam int CTL_DONE   = 10;
  localparam int CTL_TYPE   = 12;

  typedef struct packed {
    logic [63:0] base;
    logic [63:0] size;
    logic [63:0] tgt;
    logic [3:0]  gran;
    logic [3:0]  ways;
    logic        lock;
    logic        commit;
    logic        done;
    logic        expander;
  } inst_view_t;

  function automatic logic [4:0] ways_count(input logic [3:0] code);
    case (code)
      4'd0:    ways_count = 5'd1;
      4'd1:    ways_count = 5'd2;
      4'd2:    ways_count = 5'd4;
      4'd3:    ways_count = 5'd8;
      4'd4:    ways_count = 5'd16;
      4'd8:    ways_count = 5'd3;
      4'd9:    ways_count = 5'd6;
      4'd10:   ways_count = 5'd12;
      default: ways_count = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/mdec_addr_dec.sv
module mdec_addr_dec
  import mdec_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_INST = 4,
  parameter int IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_cap,
  output logic              is_gctl,
  output logic              inst_hit,
  output logic [IDX_W-1:0]  idx,
  output sub_e              sub
);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] idx_full;
  logic              low_zone;

  always_comb begin
    is_cap   = (addr == ADDR_W'(0));
    is_gctl  = (addr == ADDR_W'(4));
    low_zone = (addr < ADDR_W'(16));
    off      = addr - ADDR_W'(16);
    idx_full = off >> 5;
    case (off[4:0])
      5'h00:   sub = SUB_BLO;
      5'h04:   sub = SUB_BHI;
      5'h08:   sub = SUB_SLO;
      5'h0C:   sub = SUB_SHI;
      5'h10:   sub = SUB_CTRL;
      5'h14:   sub = SUB_TLO;
      5'h18:   sub = SUB_THI;
      default: sub = SUB_NONE;
    endcase
    inst_hit = !low_zone && (sub != SUB_NONE) && (idx_full < ADDR_W'(NUM_INST));
    idx      = idx_full[IDX_W-1:0];
  end

endmodule

// File: rtl/mdec_inst.sv
module mdec_inst
  import mdec_pkg::*;
#(
  parameter int COMMIT_DELAY = 16,
  localparam int CNT_W = $clog2(COMMIT_DELAY + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  sub_e        sub,
  input  logic [31:0] wdata,
  output logic [31:0] rd_word,
  output inst_view_t  view
);

  logic [63:0]      base_q, size_q, tgt_q;
  logic [31:0]      base_stg, size_stg;
  logic [3:0]       gran_q, ways_q;
  logic             lock_q, commit_q, done_q, type_q;
  logic [CNT_W-1:0] cnt_q;
  logic             frozen, ctrl_wr;

  assign frozen  = lock_q & done_q;
  assign ctrl_wr = wr_en && (sub == SUB_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      size_q   <= '0;
      tgt_q    <= '0;
      base_stg <= '0;
      size_stg <= '0;
      gran_q   <= '0;
      ways_q   <= '0;
      lock_q   <= 1'b0;
      type_q   <= 1'b0;
    end else if (wr_en && !frozen) begin
      case (sub)
        SUB_BHI: base_stg <= wdata;
        SUB_BLO: base_q   <= {base_stg, wdata};
        SUB_SHI: size_stg <= wdata;
        SUB_SLO: size_q   <= {size_stg, wdata};
        SUB_TLO: tgt_q[31:0]  <= wdata;
        SUB_THI: tgt_q[63:32] <= wdata;
        SUB_CTRL: begin
          gran_q <= wdata[3:0];
          ways_q <= wdata[7:4];
          lock_q <= wdata[CTL_LOCK];
          type_q <= wdata[CTL_TYPE];
        end
        default: ;
      endcase
    end
  end

  // commit handshake and its timer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (ctrl_wr && !wdata[CTL_COMMIT]) begin
      commit_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (ctrl_wr && !commit_q) begin
      commit_q <= 1'b1;
      cnt_q    <= '0;
    end else if (commit_q && !done_q) begin
      if (cnt_q == CNT_W'(COMMIT_DELAY - 1)) done_q <= 1'b1;
      else                                   cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (sub)
      SUB_BLO:  rd_word = base_q[31:0];
      SUB_BHI:  rd_word = base_q[63:32];
      SUB_SLO:  rd_word = size_q[31:0];
      SUB_SHI:  rd_word = size_q[63:32];
      SUB_TLO:  rd_word = tgt_q[31:0];
      SUB_THI:  rd_word = tgt_q[63:32];
      SUB_CTRL: rd_word = {19'b0, type_q, 1'b0, done_q, commit_q, lock_q, ways_q, gran_q};
      default:  rd_word = '0;
    endcase
  end

  always_comb begin
    view.base     = base_q;
    view.size     = size_q;
    view.tgt      = tgt_q;
    view.gran     = gran_q;
    view.ways     = ways_q;
    view.lock     = lock_q;
    view.commit   = commit_q;
    view.done     = done_q;
    view.expander = type_q;
  end

endmodule

// File: rtl/mdec_regbank.sv
module mdec_regbank
  import mdec_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int NUM_INST     = 4,
  parameter int TGT_CNT      = 2,
  parameter int IL_LO        = 1,
  parameter int IL_HI        = 0,
  parameter int COMMIT_DELAY = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_rvalid,
  output logic                    glb_enable,
  output logic [NUM_INST*64-1:0]  dec_base,
  output logic [NUM_INST*64-1:0]  dec_size,
  output logic [NUM_INST*64-1:0]  dec_targets,
  output logic [NUM_INST*5-1:0]   dec_ways,
  output logic [NUM_INST*5-1:0]   dec_gran_log2,
  output logic [NUM_INST-1:0]     dec_expander,
  output logic [NUM_INST-1:0]     dec_committed
);

  localparam int IDX_W = (NUM_INST > 1) ? $clog2(NUM_INST) : 1;
  localparam logic [31:0] CAP_WORD =
    {22'b0, 1'(IL_HI), 1'(IL_LO), 4'(TGT_CNT), 4'(NUM_INST)};

  logic             is_cap, is_gctl, inst_hit;
  logic [IDX_W-1:0] idx;
  sub_e             sub;
  logic             gen_q;
  logic [31:0]      rd_next;
  logic [31:0]      inst_rd [NUM_INST];
  logic [NUM_INST-1:0] commit_v, lock_v;

  mdec_addr_dec #(.ADDR_W(ADDR_W), .NUM_INST(NUM_INST), .IDX_W(IDX_W)) dec_i (
    .addr(bus_addr), .is_cap(is_cap), .is_gctl(is_gctl),
    .inst_hit(inst_hit), .idx(idx), .sub(sub)
  );

  generate
    for (genvar g = 0; g < NUM_INST; g++) begin : g_inst
      inst_view_t view;
      mdec_inst #(.COMMIT_DELAY(COMMIT_DELAY)) inst_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr && inst_hit && (idx == IDX_W'(g))),
        .sub(sub), .wdata(bus_wdata),
        .rd_word(inst_rd[g]), .view(view)
      );
      assign dec_base[g*64 +: 64]     = view.base;
      assign dec_size[g*64 +: 64]     = view.done ? view.size : 64'd0;
      assign dec_targets[g*64 +: 64]  = view.tgt;
      assign dec_ways[g*5 +: 5]       = ways_count(view.ways);
      assign dec_gran_log2[g*5 +: 5]  = 5'd8 + {1'b0, view.gran};
      assign dec_expander[g]          = view.expander;
      assign dec_committed[g]         = view.done;
      assign commit_v[g]              = view.commit;
      assign lock_v[g]                = view.lock;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                  gen_q <= 1'b0;
    else if (bus_wr && is_gctl)  gen_q <= bus_wdata[1];
  end
  assign glb_enable = gen_q;

  always_comb begin
    if (is_cap)        rd_next = CAP_WORD;
    else if (is_gctl)  rd_next = {30'b0, gen_q, 1'b0};
    else if (inst_hit) rd_next = inst_rd[idx];
    else               rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_next;
    end
  end

endmodule

// File: rtl/mdec_checker.sv
module mdec_checker #(
  parameter int NUM_INST     = 4,
  parameter int COMMIT_DELAY = 16,
  localparam int CW = $clog2(COMMIT_DELAY + 2)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_rd,
  input logic                   bus_rvalid,
  input logic [NUM_INST-1:0]    dec_committed,
  input logic [NUM_INST-1:0]    commit_v,
  input logic [NUM_INST-1:0]    lock_v,
  input logic [NUM_INST*64-1:0] dec_base,
  input logic [NUM_INST*64-1:0] dec_targets
);

  assert_rvalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  assert_no_rvalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  generate
    for (genvar g = 0; g < NUM_INST; g++) begin : g_chk
      logic [CW-1:0] held;
      always_ff @(posedge clk) begin
        if (!rst_n || !commit_v[g])               held <= '0;
        else if (held != CW'(COMMIT_DELAY + 1))   held <= held + 1'b1;
      end

      assert_commit_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_committed[g]) |-> (held == CW'(COMMIT_DELAY)));
      assert_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_v[g] |-> !dec_committed[g]);
      assert_frozen_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_committed[g] && lock_v[g]) |=> $stable(dec_base[g*64 +: 64]));
      assert_frozen_tgt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_committed[g] && lock_v[g]) |=> $stable(dec_targets[g*64 +: 64]));
    end
  endgenerate

endmodule

bind mdec_regbank mdec_checker #(.NUM_INST(NUM_INST), .COMMIT_DELAY(COMMIT_DELAY)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .dec_committed(dec_committed), .commit_v(commit_v), .lock_v(lock_v),
  .dec_base(dec_base), .dec_targets(dec_targets)
);

// File: tb/mdec_regbank_tb.sv
`timescale 1ns/1ps
module mdec_regbank_tb_top;

  localparam int ADDR_W = 12;
  localparam int NI     = 4;
  localparam int TC     = 2;
  localparam int ILL    = 1;
  localparam int ILH    = 0;
  localparam int DLY    = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid, glb_enable;
  logic [NI*64-1:0]  dec_base, dec_size, dec_targets;
  logic [NI*5-1:0]   dec_ways, dec_gran_log2;
  logic [NI-1:0]     dec_expander, dec_committed;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mdec_regbank #(.ADDR_W(ADDR_W), .NUM_INST(NI), .TGT_CNT(TC), .IL_LO(ILL),
                 .IL_HI(ILH), .COMMIT_DELAY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .glb_enable(glb_enable), .dec_base(dec_base),
    .dec_size(dec_size), .dec_targets(dec_targets), .dec_ways(dec_ways),
    .dec_gran_log2(dec_gran_log2), .dec_expander(dec_expander),
    .dec_committed(dec_committed)
  );

  function automatic int ra(input int i, input int sub_off);
    return 32'h20 * i + 32'h10 + sub_off;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rvalid", 64'(bus_rvalid), 0);
    check("R1 committed", 64'(dec_committed), 0);
    check("R1 enable", 64'(glb_enable), 0);
    rd(ra(0, 'h0), d);  check("R1 base lo", 64'(d), 0);
    rd(ra(2, 'h10), d); check("R1 ctrl", 64'(d), 0);
    check("R1 size out", dec_size[0 +: 64], 0);
  endtask

  task automatic t_rlat();
    logic [31:0] d;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = '0;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R4 rvalid high", 64'(bus_rvalid), 1);
    @(negedge clk);
    check("R4 rvalid low", 64'(bus_rvalid), 0);
    rd(4, d);
  endtask

  task automatic t_cap();
    logic [31:0] d;
    logic [31:0] e;
    e = NI | (TC << 4) | (ILL << 8) | (ILH << 9);
    wr(0, 32'hFFFF_FFFF);
    rd(0, d);
    check("R2 capability word", 64'(d), 64'(e));
  endtask

  task automatic t_gctl();
    logic [31:0] d;
    wr(4, 32'hFFFF_FFFF);
    rd(4, d);
    check("R3 gctl read", 64'(d), 2);
    check("R3 enable pin", 64'(glb_enable), 1);
    wr(4, 32'hFFFF_FFFD);
    rd(4, d);
    check("R3 gctl cleared", 64'(d), 0);
    check("R3 enable pin low", 64'(glb_enable), 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    for (int i = 0; i < NI; i++) begin
      wr(ra(i, 'h14), 32'hA0 + i);
      wr(ra(i, 'h18), 32'hB0 + i);
      wr(ra(i, 'hC), i + 1);
      wr(ra(i, 'h8), 32'h100 * i);
    end
    for (int i = 0; i < NI; i++) begin
      rd(ra(i, 'h14), d); check("R5 tlist lo", 64'(d), 64'(32'hA0 + i));
      rd(ra(i, 'h18), d); check("R5 tlist hi", 64'(d), 64'(32'hB0 + i));
      rd(ra(i, 'hC), d);  check("R5 size hi", 64'(d), 64'(i + 1));
      rd(ra(i, 'h8), d);  check("R5 size lo", 64'(d), 64'(32'h100 * i));
      check("R5 targets out", dec_targets[i*64 +: 64], {32'hB0 + i, 32'hA0 + i});
    end
  endtask

  task automatic t_atomic();
    logic [31:0] d;
    wr(ra(1, 'h4), 32'h11);
    wr(ra(1, 'h0), 32'h22);
    check("R6 base pair", dec_base[64 +: 64], 64'h11_0000_0022);
    wr(ra(1, 'h4), 32'h33);
    rd(ra(1, 'h4), d);
    check("R6 staged hi hidden", 64'(d), 64'h11);
    check("R6 staged out hidden", dec_base[64 +: 64], 64'h11_0000_0022);
    wr(ra(1, 'h0), 32'h44);
    check("R6 low completes", dec_base[64 +: 64], 64'h33_0000_0044);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(ra(2, 'h10), 32'hFFFF_FDFF);
    rd(ra(2, 'h10), d);
    check("R7 ctrl fields", 64'(d), 64'h11FF);
    check("R12 ways bad code", 64'(dec_ways[10 +: 5]), 0);
    check("R12 expander", 64'(dec_expander[2]), 1);
    wr(ra(2, 'h10), 32'h93);
    check("R12 ways 3x2", 64'(dec_ways[10 +: 5]), 6);
    check("R12 gran", 64'(dec_gran_log2[10 +: 5]), 11);
    check("R12 accelerator", 64'(dec_expander[2]), 0);
    wr(ra(2, 'h10), 32'h40);
    check("R12 ways 16", 64'(dec_ways[10 +: 5]), 16);
    check("R12 gran 256", 64'(dec_gran_log2[10 +: 5]), 8);
  endtask

  task automatic t_commit();
    logic [31:0] d;
    wr(ra(0, 'h4), 0);  wr(ra(0, 'h0), 32'h1000_0000);
    wr(ra(0, 'hC), 0);  wr(ra(0, 'h8), 32'h0010_0000);
    wr(ra(0, 'h10), 32'h1212);
    repeat (DLY - 1) @(negedge clk);
    check("R8 not yet committed", 64'(dec_committed[0]), 0);
    check("R12 size hidden", dec_size[0 +: 64], 0);
    @(negedge clk);
    check("R8 committed on time", 64'(dec_committed[0]), 1);
    check("R12 size shown", dec_size[0 +: 64], 64'h10_0000);
    check("R12 ways 2", 64'(dec_ways[0 +: 5]), 2);
    check("R12 gran 1K", 64'(dec_gran_log2[0 +: 5]), 10);
    rd(ra(0, 'h10), d);
    check("R7 committed readback", 64'(d), 64'h1612);
    wr(ra(0, 'h10), 32'h1012);
    check("R9 commit clear", 64'(dec_committed[0]), 0);
    check("R9 size hidden", dec_size[0 +: 64], 0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(ra(3, 'h4), 1);  wr(ra(3, 'h0), 32'h2000);
    wr(ra(3, 'h14), 32'h0302);
    wr(ra(3, 'h10), 32'h300);
    repeat (DLY + 1) @(negedge clk);
    check("R10 locked committed", 64'(dec_committed[3]), 1);
    wr(ra(3, 'h4), 32'hAA); wr(ra(3, 'h0), 32'hBB);
    wr(ra(3, 'h8), 32'hCC); wr(ra(3, 'h14), 32'hDD);
    wr(ra(3, 'h10), 32'h13FF);
    check("R10 base frozen", dec_base[192 +: 64], 64'h1_0000_2000);
    check("R10 tlist frozen", dec_targets[192 +: 32], 64'h0302);
    rd(ra(3, 'h8), d);  check("R10 size frozen", 64'(d), 64'h300);
    rd(ra(3, 'h10), d); check("R10 ctrl frozen", 64'(d), 64'h700);
    wr(ra(3, 'h10), 0);
    check("R10 clear accepted", 64'(dec_committed[3]), 0);
    wr(ra(3, 'h4), 5); wr(ra(3, 'h0), 6);
    check("R10 unlocked write", dec_base[192 +: 64], 64'h5_0000_0006);
  endtask

  task automatic t_holes();
    logic [31:0] d;
    wr(8, 32'hFFFF_FFFF);
    wr(ra(NI, 'h0), 32'hFFFF_FFFF);
    wr(ra(0, 'h1C), 32'hFFFF_FFFF);
    rd(8, d);          check("R11 hole 0x8", 64'(d), 0);
    rd('hC, d);        check("R11 hole 0xC", 64'(d), 0);
    rd(ra(0, 'h1C), d); check("R11 slot 0x2C", 64'(d), 0);
    rd(ra(NI, 'h0), d); check("R11 past last instance", 64'(d), 0);
    rd(ra(NI, 'h10), d); check("R11 past last ctrl", 64'(d), 0);
    check("R11 no alias base", dec_base[0 +: 64], 64'h1000_0000);
    check("R11 no enable", 64'(glb_enable), 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rlat();
    t_cap();
    t_gctl();
    t_layout();
    t_atomic();
    t_ctrl();
    t_commit();
    t_lock();
    t_holes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule